// File: doc/BRIEF.md
# Serial EEPROM Write-Path Target

This block is the write side of a small two-wire serial EEPROM, modelled in RTL. A fast system clock oversamples SCL and SDA through two-flop synchronisers. Start and Stop conditions are recovered from the synchronised lines, and the block follows a write transaction one bit at a time. The transaction has three parts: a device select byte, one word-address byte, and one or more data bytes. Each accepted byte is acknowledged by enabling an open-drain pull-down on SDA during the ninth clock. Accepted data bytes go into a 16-byte page buffer.

A Stop placed in the slot right after an acknowledge slot starts a write cycle that lasts a fixed number of clocks. At the end of that cycle the buffered bytes are copied into a 256 x 8 register-file array. A write-lock input, sampled from Start to the end of the address byte, turns every data acknowledge into a NoAck. While the write cycle runs, the block ignores the bus. A combinational observation port returns the contents of any array location.

Top module: `eepw_top`

## Requirements
- R1: A device select byte is acknowledged only when bits 7:4 are 1010, bits 3:1 equal `chip_sel_i`, and bit 0 (read/write) is 0. Any other byte gets no acknowledge, and the block waits for the next Start.
- R2: After an acknowledged device select, the next byte is taken as the word address and is acknowledged. An acknowledge holds `sda_oe_o` high through the ninth SCL high phase. Outside acknowledge slots `sda_oe_o` is low.
- R3: Without a lock, every data byte is acknowledged and buffered at the current address. Only address bits 3:0 advance from one byte to the next; bits 7:4 stay fixed.
- R4: When a burst runs past the end of its 16-byte page, the address wraps to the start of the same page. A later byte replaces the earlier buffered byte at the same location.
- R5: If `wr_lock_i` is high at any time from Start to the end of the address byte, every data byte gets a NoAck and no location changes. A lock asserted only during the data bytes has no effect.
- R6: A Stop in the slot right after the acknowledge of a data byte, with at least one byte accepted, raises `busy_o` for exactly WRITE_CYCLES clocks. When `busy_o` falls, exactly the buffered locations hold their new values and every other location is unchanged.
- R7: A Stop at any other point, including inside a byte, ends the transaction with no write cycle and no array change.
- R8: While `busy_o` is high, the bus is ignored: `sda_oe_o` stays low, even for a matching device select.
- R9: A repeated Start discards the bytes buffered so far without writing them, and device select decoding begins again.
- R10: After reset, `sda_oe_o` and `busy_o` are low and every array location reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| chip_sel_i | input | 3 | Strap value compared with device select bits 3:1 |
| wr_lock_i | input | 1 | Write lock, sampled from Start to the end of the address byte |
| sda_oe_o | output | 1 | High pulls SDA low (acknowledge) |
| busy_o | output | 1 | Internal write cycle in progress |
| peek_addr_i | input | 8 | Array observation address |
| peek_data_o | output | 8 | Array contents at `peek_addr_i` |

## Verification
The assertions assume that SCL and SDA never change in the same system clock, so a Start or Stop can never coincide with an SCL edge. They also assume that each SCL phase is long enough for the synchroniser delay to settle before the next edge. The bench's bit driver keeps SDA changes inside the SCL-low phase, except for deliberate Start and Stop conditions, and holds each quarter bit for four system clocks. The bench also assumes that a controller does not raise SCL again while the target still holds an acknowledge from the previous falling edge. The quarter-bit wait is longer than the synchroniser latency, which satisfies that assumption.

// File: rtl/eepw_pkg.sv
package eepw_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_DEVSEL = 2'd1,
    PH_ADDR   = 2'd2,
    PH_DATA   = 2'd3
  } phase_e;

  localparam logic [3:0] DEV_CLASS = 4'b1010;
endpackage

// File: rtl/eepw_line_sync.sv
module eepw_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_pipe_q, sda_pipe_q;
  logic scl_d_q, sda_d_q;
  logic scl_s, sda_s;

  assign scl_s = scl_pipe_q[STAGES-1];
  assign sda_s = sda_pipe_q[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_pipe_q <= '1;
      sda_pipe_q <= '1;
      scl_d_q    <= 1'b1;
      sda_d_q    <= 1'b1;
    end else begin
      scl_pipe_q <= {scl_pipe_q[STAGES-2:0], scl_i};
      sda_pipe_q <= {sda_pipe_q[STAGES-2:0], sda_i};
      scl_d_q    <= scl_s;
      sda_d_q    <= sda_s;
    end
  end

  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_d_q;
  assign scl_fall_o = ~scl_s & scl_d_q;
  assign start_o    = scl_s & scl_d_q & sda_d_q & ~sda_s;
  assign stop_o     = scl_s & scl_d_q & ~sda_d_q & sda_s;
endmodule

// File: rtl/eepw_ctrl.sv
module eepw_ctrl
  import eepw_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              sda_i,
  input  logic [2:0]        chip_sel_i,
  input  logic              wr_lock_i,
  input  logic              busy_i,
  output logic              ack_oe_o,
  output logic              buf_clear_o,
  output logic              buf_we_o,
  output logic [PAGE_W-1:0] buf_idx_o,
  output logic [7:0]        buf_data_o,
  output logic              commit_o,
  output logic [ADDR_W-PAGE_W-1:0] page_o
);
  phase_e            phase_q, phase_d;
  logic [3:0]        bitcnt_q, bitcnt_d;
  logic [7:0]        shreg_q, shreg_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic ack_phase_q, ack_phase_d;
  logic ack_en_q, ack_en_d;
  logic boundary_q, boundary_d;
  logic lock_q, lock_d;
  logic any_q, any_d;
  logic sel_match;

  assign sel_match = (shreg_q[7:4] == DEV_CLASS) && (shreg_q[3:1] == chip_sel_i)
                     && !shreg_q[0];

  always_comb begin
    phase_d     = phase_q;
    bitcnt_d    = bitcnt_q;
    shreg_d     = shreg_q;
    addr_d      = addr_q;
    ack_phase_d = ack_phase_q;
    ack_en_d    = ack_en_q;
    boundary_d  = boundary_q;
    lock_d      = lock_q;
    any_d       = any_q;
    buf_clear_o = 1'b0;
    buf_we_o    = 1'b0;
    commit_o    = 1'b0;
    if (busy_i) begin
      // R8: bus fully ignored during the write cycle
      phase_d     = PH_IDLE;
      ack_phase_d = 1'b0;
    end else if (start_i) begin
      // R9: any Start restarts decoding and drops the buffer
      phase_d     = PH_DEVSEL;
      bitcnt_d    = '0;
      ack_phase_d = 1'b0;
      boundary_d  = 1'b0;
      lock_d      = wr_lock_i;
      any_d       = 1'b0;
      buf_clear_o = 1'b1;
    end else if (stop_i) begin
      // R6 / R7: only a Stop in the slot after a data acknowledge commits
      commit_o    = (phase_q == PH_DATA) && boundary_q && any_q;
      phase_d     = PH_IDLE;
      ack_phase_d = 1'b0;
    end else if (phase_q != PH_IDLE) begin
      if (phase_q == PH_DEVSEL || phase_q == PH_ADDR) begin
        lock_d = lock_q | wr_lock_i;
      end
      if (scl_rise_i && !ack_phase_q && bitcnt_q < 4'd8) begin
        shreg_d  = {shreg_q[6:0], sda_i};
        bitcnt_d = bitcnt_q + 4'd1;
      end
      if (scl_fall_i) begin
        if (ack_phase_q) begin
          ack_phase_d = 1'b0;
          bitcnt_d    = '0;
          boundary_d  = 1'b1;
        end else if (bitcnt_q == 4'd8) begin
          unique case (phase_q)
            PH_DEVSEL: begin
              if (sel_match) begin
                ack_phase_d = 1'b1;
                ack_en_d    = 1'b1;
                phase_d     = PH_ADDR;
              end else begin
                phase_d = PH_IDLE;
              end
            end
            PH_ADDR: begin
              ack_phase_d = 1'b1;
              ack_en_d    = 1'b1;
              addr_d      = shreg_q[ADDR_W-1:0];
              phase_d     = PH_DATA;
            end
            default: begin
              ack_phase_d = 1'b1;
              ack_en_d    = !lock_q;
              if (!lock_q) begin
                // R3 / R4: low address bits wrap inside the page
                buf_we_o = 1'b1;
                any_d    = 1'b1;
                addr_d   = {addr_q[ADDR_W-1:PAGE_W], addr_q[PAGE_W-1:0] + PAGE_W'(1)};
              end
            end
          endcase
        end else if (bitcnt_q == 4'd1) begin
          boundary_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q     <= PH_IDLE;
      bitcnt_q    <= '0;
      shreg_q     <= '0;
      addr_q      <= '0;
      ack_phase_q <= 1'b0;
      ack_en_q    <= 1'b0;
      boundary_q  <= 1'b0;
      lock_q      <= 1'b0;
      any_q       <= 1'b0;
    end else begin
      phase_q     <= phase_d;
      bitcnt_q    <= bitcnt_d;
      shreg_q     <= shreg_d;
      addr_q      <= addr_d;
      ack_phase_q <= ack_phase_d;
      ack_en_q    <= ack_en_d;
      boundary_q  <= boundary_d;
      lock_q      <= lock_d;
      any_q       <= any_d;
    end
  end

  assign ack_oe_o   = ack_phase_q & ack_en_q;
  assign buf_idx_o  = addr_q[PAGE_W-1:0];
  assign buf_data_o = shreg_q;
  assign page_o     = addr_q[ADDR_W-1:PAGE_W];

  // R2
  ack_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_oe_o) |-> $past(scl_fall_i));

  // R2
  ack_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ack_oe_o) |-> $past(scl_fall_i || start_i || stop_i || busy_i));

  // R6
  commit_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> (phase_q == PH_IDLE) && !ack_oe_o);
endmodule

// File: rtl/eepw_store.sv
module eepw_store #(
  parameter int ADDR_W       = 8,
  parameter int PAGE_W       = 4,
  parameter int WRITE_CYCLES = 5000
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clear_i,
  input  logic                     buf_we_i,
  input  logic [PAGE_W-1:0]        buf_idx_i,
  input  logic [7:0]               buf_data_i,
  input  logic                     commit_i,
  input  logic [ADDR_W-PAGE_W-1:0] page_i,
  input  logic [ADDR_W-1:0]        peek_addr_i,
  output logic                     busy_o,
  output logic [7:0]               peek_data_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE  = 1 << PAGE_W;
  localparam int CNT_W = $clog2(WRITE_CYCLES + 1);
  localparam int TOP_W = ADDR_W - PAGE_W;

  logic [7:0]       pbuf_q [PAGE];
  logic [PAGE-1:0]  pvld_q;
  logic [7:0]       mem_q  [DEPTH];
  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [TOP_W-1:0] page_q, page_d;
  logic             done;

  assign done = busy_q && (cnt_q == '0);

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    page_d = page_q;
    if (commit_i && !busy_q) begin
      busy_d = 1'b1;
      cnt_d  = CNT_W'(WRITE_CYCLES - 1);
      page_d = page_i;
    end else if (busy_q) begin
      if (done) busy_d = 1'b0;
      else      cnt_d  = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      page_q <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      page_q <= page_d;
    end
  end

  // page buffer data: no reset, qualified by the valid flags
  always_ff @(posedge clk_i) begin
    if (buf_we_i) pbuf_q[buf_idx_i] <= buf_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pvld_q <= '0;
    end else if (clear_i || done) begin
      pvld_q <= '0;
    end else if (buf_we_i) begin
      pvld_q[buf_idx_i] <= 1'b1;
    end
  end

  // R6: only flagged bytes land in the array, at the end of the cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int a = 0; a < DEPTH; a++) mem_q[a] <= '0;
    end else if (done) begin
      for (int k = 0; k < PAGE; k++) begin
        if (pvld_q[k]) mem_q[{page_q, PAGE_W'(k)}] <= pbuf_q[k];
      end
    end
  end

  assign busy_o      = busy_q;
  assign peek_data_o = mem_q[peek_addr_i];

  // checker state: independent busy-length counter
  int chk_len;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     chk_len <= 0;
    else if (busy_q) chk_len <= chk_len + 1;
    else             chk_len <= 0;
  end

  // R6
  busy_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> (chk_len == WRITE_CYCLES));

  // R8
  no_commit_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |-> !busy_q);

  // R8
  no_fill_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_we_i |-> !busy_q);
endmodule

// File: rtl/eepw_top.sv
module eepw_top #(
  parameter int ADDR_W       = 8,
  parameter int PAGE_W       = 4,
  parameter int SYNC_STAGES  = 2,
  parameter int WRITE_CYCLES = 5000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [2:0]        chip_sel_i,
  input  logic              wr_lock_i,
  output logic              sda_oe_o,
  output logic              busy_o,
  input  logic [ADDR_W-1:0] peek_addr_i,
  output logic [7:0]        peek_data_o
);
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic buf_clear, buf_we, commit, ack_oe;
  logic [PAGE_W-1:0] buf_idx;
  logic [7:0] buf_data;
  logic [ADDR_W-PAGE_W-1:0] page;

  eepw_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_i(sda_i),
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  eepw_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_det), .stop_i(stop_det), .sda_i(sda_s),
    .chip_sel_i(chip_sel_i), .wr_lock_i(wr_lock_i), .busy_i(busy_o),
    .ack_oe_o(ack_oe), .buf_clear_o(buf_clear), .buf_we_o(buf_we),
    .buf_idx_o(buf_idx), .buf_data_o(buf_data), .commit_o(commit), .page_o(page)
  );

  eepw_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WRITE_CYCLES(WRITE_CYCLES)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(buf_clear), .buf_we_i(buf_we),
    .buf_idx_i(buf_idx), .buf_data_i(buf_data), .commit_i(commit), .page_i(page),
    .peek_addr_i(peek_addr_i), .busy_o(busy_o), .peek_data_o(peek_data_o)
  );

  assign sda_oe_o = ack_oe;

  // R8
  quiet_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !sda_oe_o);
endmodule

// File: tb/tb_eepw_top.sv
module tb_eepw_top;
  localparam int WCYC = 300;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] DEV_OK = {4'b1010, STRAP, 1'b0};

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, scl, m_sda, lock, sda_line, sda_oe, busy_o;
  logic [7:0] peek_addr, peek_data;
  assign sda_line = m_sda & ~sda_oe;

  eepw_top #(.WRITE_CYCLES(WCYC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
    .chip_sel_i(STRAP), .wr_lock_i(lock), .sda_oe_o(sda_oe), .busy_o(busy_o),
    .peek_addr_i(peek_addr), .peek_data_o(peek_data)
  );

  int checks = 0, fails = 0;
  int mem_m [256];
  int pend_v [256];
  bit pend_f [256];
  bit pending = 1'b0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic qwait();
    repeat (4) @(negedge clk);
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; qwait(); scl = 1'b1; qwait(); m_sda = 1'b0; qwait(); scl = 1'b0; qwait();
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; qwait(); scl = 1'b1; qwait(); m_sda = 1'b1; qwait(); qwait();
  endtask

  task automatic send_bits(input logic [7:0] b, input int nb, output bit oe_seen);
    oe_seen = 1'b0;
    for (int i = 7; i > 7 - nb; i--) begin
      m_sda = b[i]; qwait(); scl = 1'b1; qwait();
      if (sda_oe) oe_seen = 1'b1;
      qwait(); scl = 1'b0; qwait();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    bit oe_seen;
    send_bits(b, 8, oe_seen);
    chk(!oe_seen, "R2 SDA released outside ack slot", oe_seen, 0);
    m_sda = 1'b1; qwait(); scl = 1'b1; qwait();
    ack = sda_oe;
    qwait(); scl = 1'b0; qwait();
  endtask

  task automatic no_busy(input string tag);
    bit seen = 1'b0;
    repeat (40) begin
      @(negedge clk);
      if (busy_o) seen = 1'b1;
    end
    chk(!seen, tag, seen, 0);
  endtask

  task automatic wait_commit();
    int t = 0;
    while (pending && t < WCYC + 1000) begin
      @(negedge clk);
      t++;
    end
    chk(!pending, "R6 write cycle completes", pending, 0);
  endtask

  // lmode: 0 none, 1 whole, 2 address phase only, 3 data phase only
  // endm : 0 stop after ack, 1 stop inside a byte, 2 leave open
  task automatic write_txn(input logic [7:0] dev, input logic [7:0] addr, input int n,
                           input int base, input int lmode, input int endm, input bit wait_c);
    bit a, dev_ok, eff, any, junk;
    int stg_v [16];
    bit stg_f [16];
    for (int k = 0; k < 16; k++) stg_f[k] = 1'b0;
    any = 1'b0;
    lock = (lmode == 1 || lmode == 2);
    i2c_start();
    send_byte(dev, a);
    dev_ok = (dev[7:4] == 4'b1010) && (dev[3:1] == STRAP) && !dev[0];
    chk(a == dev_ok, "R1 device select ack", a, dev_ok);
    if (!dev_ok) begin
      i2c_stop();
      lock = 1'b0;
      no_busy("R1 no write after rejected select");
      return;
    end
    send_byte(addr, a);
    chk(a == 1'b1, "R2 address ack", a, 1);
    lock = (lmode == 1 || lmode == 3);
    eff  = (lmode == 1 || lmode == 2);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      d = 8'((base + i * 7) & 255);
      send_byte(d, a);
      if (eff) chk(a == 1'b0, "R5 locked data NoAck", a, 0);
      else     chk(a == 1'b1, "R3 data ack", a, 1);
      if (!eff) begin
        stg_v[(int'(addr) + i) & 15] = d;   // R4 wrap and overwrite
        stg_f[(int'(addr) + i) & 15] = 1'b1;
        any = 1'b1;
      end
    end
    lock = 1'b0;
    if (endm == 0) begin
      if (any) begin
        for (int k = 0; k < 16; k++) begin
          if (stg_f[k]) begin
            pend_v[(int'(addr) & 8'hF0) | k] = stg_v[k];
            pend_f[(int'(addr) & 8'hF0) | k] = 1'b1;
          end
        end
        pending = 1'b1;
      end
      i2c_stop();
      if (any && wait_c) wait_commit();
      if (!any) no_busy("R5 no write cycle when locked");
    end else if (endm == 1) begin
      send_bits(8'h5A, 3, junk);
      i2c_stop();
      no_busy("R7 mid-byte stop aborts");
    end
  endtask

  // per-clock reference comparison: busy length and array contents
  initial begin
    int busy_run = 0;
    peek_addr = 8'h00;
    forever begin
      @(negedge clk);
      if (rst_n === 1'b1) begin
        if (busy_o) begin
          busy_run++;
        end else begin
          if (busy_run != 0) begin
            chk(busy_run == WCYC, "R6 busy length", busy_run, WCYC);
            chk(pending, "R7 unexpected write cycle", pending, 1);
            for (int k = 0; k < 256; k++) begin
              if (pend_f[k]) mem_m[k] = pend_v[k];
              pend_f[k] = 1'b0;
            end
            pending = 1'b0;
            busy_run = 0;
          end
          chk(int'(peek_data) == mem_m[peek_addr], "R6 array content", peek_data, mem_m[peek_addr]);
        end
        peek_addr = peek_addr + 8'd1;
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit a;
    for (int k = 0; k < 256; k++) begin
      mem_m[k] = 0;
      pend_f[k] = 1'b0;
    end
    rst_n = 1'b0; scl = 1'b1; m_sda = 1'b1; lock = 1'b0;
    repeat (5) @(negedge clk);
    chk(sda_oe == 1'b0, "R10 reset sda_oe", sda_oe, 0);
    chk(busy_o == 1'b0, "R10 reset busy", busy_o, 0);
    chk(peek_data == 8'h00, "R10 reset array", peek_data, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    write_txn(DEV_OK, 8'h25, 1, 8'hA5, 0, 0, 1);    // R3 byte write
    write_txn(DEV_OK, 8'h40, 4, 8'h10, 0, 0, 1);    // R3 page write
    write_txn(DEV_OK, 8'h7E, 5, 8'h31, 0, 0, 1);    // R4 wrap
    write_txn(DEV_OK, 8'h90, 18, 8'h55, 0, 0, 1);   // R4 overwrite after wrap
    write_txn(DEV_OK, 8'h30, 2, 8'h99, 1, 0, 1);    // R5 lock whole
    write_txn(DEV_OK, 8'h31, 2, 8'h21, 2, 0, 1);    // R5 lock in address only
    write_txn(DEV_OK, 8'h32, 2, 8'h66, 3, 0, 1);    // R5 lock in data only: no effect
    write_txn(8'hA8, 8'h00, 1, 8'h01, 0, 0, 1);     // R1 wrong strap
    write_txn(8'hBA, 8'h00, 1, 8'h01, 0, 0, 1);     // R1 wrong class
    write_txn(8'hAB, 8'h00, 1, 8'h01, 0, 0, 1);     // R1 read bit set
    write_txn(DEV_OK, 8'h60, 2, 8'h77, 0, 1, 1);    // R7 stop inside byte
    write_txn(DEV_OK, 8'h50, 1, 8'h11, 0, 2, 0);    // R9 left open
    write_txn(DEV_OK, 8'h53, 1, 8'h22, 0, 0, 1);    // R9 restart, only this write lands
    write_txn(DEV_OK, 8'hC0, 3, 8'h44, 0, 0, 0);    // R8 probe during busy
    chk(busy_o == 1'b1, "R8 write cycle running", busy_o, 1);
    i2c_start();
    send_byte(DEV_OK, a);
    chk(a == 1'b0, "R8 select ignored while busy", a, 0);
    i2c_stop();
    wait_commit();
    write_txn(DEV_OK, 8'hC8, 1, 8'h3C, 0, 0, 1);    // R8 responds again afterwards
    repeat (300) @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule